// File: doc/BRIEF.md
# PWM Dead-Time and Fault Guard

This block sits between a four-channel compare timer and the output pins. Each timer channel's waveform can be turned into a complementary pair of pin drives: a high-side pin and a low-side pin. After every waveform edge both pins are held low for a programmable gap, so that the two switches of a half bridge are never on together. A channel whose generator is disabled passes its raw waveform straight to its high-side pin. A broadcast mode feeds all four generators from channel A. A pattern mode bypasses the generators and drives the pins from a stored bit pattern, which is taken from the low-side dead-time register at the timer's update event.

Eight event inputs are filtered through a mask and ORed into a single fault condition. A fault sets a sticky flag, which software clears by writing 1. It also carries out one of these actions: none, force every pin low, or clear the channel generator enables. The forced-low state either stays until the flag is cleared (latched) or ends at the first timer period boundary on which no fault is present (cycle-by-cycle).

Top module: `pwm_dt_guard`

## Requirements
- R1: After reset every register reads 0 and all eight pins are 0.
- R2: Register map on the 3-bit address. 0: generator enables in bits 3:0 (channel A in bit 0), broadcast in bit 4, pattern mode in bit 5, bits 7:6 read 0. 1: event mask. 2: fault action in bits 1:0, fault mode in bit 2 (1 = cycle-by-cycle), debug-break bit in bit 4, the other bits read 0. 3: fault flag in bit 0; writing 1 to bit 0 clears it. 4: low-side dead time. 5: high-side dead time. Other addresses read 0.
- R3: Channel k owns pins 2k (low side) and 2k+1 (high side). With its enable clear, pin 2k+1 carries the raw waveform k without delay and pin 2k is 0.
- R4: With the enable set, a rising input edge sampled at a clock edge holds both pins low for exactly high-side-count+1 clock cycles, then pin 2k+1 goes high. A falling edge holds both pins low for low-side-count+1 cycles, then pin 2k goes high.
- R5: A new edge that arrives during a gap restarts the gap with the count for the new level. The two pins of an enabled channel are never high together.
- R6: In broadcast mode every generator takes waveform A. Waveforms B, C and D have no effect on enabled channels.
- R7: In pattern mode pin i is bit i of the active pattern ANDed with the enable of the channel that owns pin i. The active pattern is loaded from the low-side dead-time register on each period tick, and a register write alone does not change it.
- R8: A fault is any event bit set together with its mask bit. One clock after a fault the flag reads 1. Unmasked events never set it. A clear write in the same cycle as a fault leaves the flag set.
- R9: Action 01 in latched mode (bit 2 = 0) drives all eight pins low from the cycle after the fault until the flag is cleared.
- R10: Action 01 in cycle-by-cycle mode drives all pins low until a period tick sampled while no fault is present. The flag stays set after the pins are released.
- R11: Action 11 clears all generator enables on a fault. Actions 00 and 10 leave pins and enables untouched.
- R12: The debug-break bit is stored and read back and has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| wave_in | input | 4 | Timer compare waveforms, channel A in bit 0 |
| period_tick | input | 1 | Timer update / period boundary pulse |
| evt_in | input | 8 | Event inputs for fault detection |
| pin_out | output | 8 | Pin drives, pin 2k low side and 2k+1 high side of channel k |

## Verification
The embedded properties watch the following on every cycle: the two drives of a generator never overlap; both drives go low after any input change; a masked event always raises the flag; the flag drops only on a clear write; the cycle-by-cycle hold is released only on a fault-free tick; the enables are gone after a clearing fault; and pattern mode never drives a pin whose pattern bit is 0. The exact gap lengths, the channel-A broadcast, the deferred pattern load, the per-mode release points and the register read-back are shown only by the bench. The bench runs a behavioural model cycle by cycle and compares its scenarios against it, adding explicit checks at each boundary.

// File: rtl/pdg_pkg.sv
// Package: shared constants and types of the PWM dead-time and fault guard.
// Assumes an 8-bit register bus with a 3-bit address.
package pdg_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_FCTL = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_DTLO = 3'd4;
    localparam logic [ADDR_W-1:0] A_DTHI = 3'd5;

    typedef enum logic [1:0] {
        FA_NONE = 2'b00,
        FA_LOW  = 2'b01,
        FA_RSVD = 2'b10,
        FA_KILL = 2'b11
    } fact_e;
endpackage

// File: rtl/pdg_dtgen.sv
// Module: one dead-time generator. Splits a waveform into high-side and
// low-side drives. On each input change both drives drop and a countdown
// is loaded (rise count for a rising edge, fall count for a falling one).
// The drives follow the waveform again once the countdown is zero.
// Assumes the input is synchronous to clk.
module pdg_dtgen #(
    parameter int unsigned DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           w_in,
    input  logic [DTW-1:0] dt_rise,
    input  logic [DTW-1:0] dt_fall,
    output logic           hs_out,
    output logic           ls_out
);
    logic           w_q;
    logic [DTW-1:0] cnt_q;
    logic           edge_now;

    // detect a level change against the previous sample
    assign edge_now = w_in ^ w_q;

    // gap counter and registered drives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q    <= 1'b0;
            cnt_q  <= '0;
            hs_out <= 1'b0;
            ls_out <= 1'b0;
        end else begin
            w_q <= w_in;
            if (edge_now) begin
                cnt_q  <= w_in ? dt_rise : dt_fall;
                hs_out <= 1'b0;
                ls_out <= 1'b0;
            end else if (cnt_q != '0) begin
                cnt_q  <= cnt_q - 1'b1;
                hs_out <= 1'b0;
                ls_out <= 1'b0;
            end else begin
                hs_out <= w_in;
                ls_out <= ~w_in;
            end
        end
    end

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_out && ls_out));

    // R4
    edge_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_in != w_q) |=> (!hs_out && !ls_out));
endmodule

// File: rtl/pdg_fault.sv
// Module: fault detector. ORs the masked events into one fault condition,
// keeps the sticky flag (cleared by software), keeps the cycle-by-cycle
// hold (released on a fault-free period tick), and derives the force-low
// and clear-enables requests from the selected action.
// Assumes events are synchronous single-cycle or level signals.
module pdg_fault #(
    parameter int unsigned NEVT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEVT-1:0]   evt_in,
    input  logic [NEVT-1:0]   evt_mask,
    input  pdg_pkg::fact_e    fault_act,
    input  logic              cbc_mode,
    input  logic              period_tick,
    input  logic              flag_clr,
    output logic              fault_flag,
    output logic              force_low,
    output logic              kill_en
);
    import pdg_pkg::*;

    logic fault_now;
    logic hold_q;

    // any enabled event source counts as a fault
    assign fault_now = |(evt_in & evt_mask);

    // sticky flag: a fault wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          fault_flag <= 1'b0;
        else if (fault_now)  fault_flag <= 1'b1;
        else if (flag_clr)   fault_flag <= 1'b0;
    end

    // cycle-by-cycle hold: ends on a tick with no fault present
    always_ff @(posedge clk) begin
        if (!rst_n)           hold_q <= 1'b0;
        else if (fault_now)   hold_q <= 1'b1;
        else if (period_tick) hold_q <= 1'b0;
    end

    // action decode
    assign force_low = (fault_act == FA_LOW) && (cbc_mode ? hold_q : fault_flag);
    assign kill_en   = fault_now && (fault_act == FA_KILL);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_now |=> fault_flag);

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_flag) |-> $past(flag_clr));

    // R10
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_q) |-> ($past(period_tick) && !$past(fault_now)));
endmodule

// File: rtl/pdg_regs.sv
// Module: register file of the guard. Holds the mode, mask, fault-control
// and dead-time registers, produces the flag-clear strobe and the read mux.
// Assumes NCH <= 4, NEVT <= 8 and DTW <= 8 (fields share 8-bit registers).
module pdg_regs #(
    parameter int unsigned NCH  = 4,
    parameter int unsigned NEVT = 8,
    parameter int unsigned DTW  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [pdg_pkg::ADDR_W-1:0] bus_addr,
    input  logic [pdg_pkg::REG_W-1:0]  bus_wdata,
    input  logic                      fault_flag,
    input  logic                      kill_en,
    output logic [NCH-1:0]            chan_en,
    output logic                      com_mode,
    output logic                      pat_mode,
    output logic [NEVT-1:0]           evt_mask,
    output pdg_pkg::fact_e            fault_act,
    output logic                      cbc_mode,
    output logic [DTW-1:0]            dt_lo,
    output logic [DTW-1:0]            dt_hi,
    output logic                      flag_clr,
    output logic [pdg_pkg::REG_W-1:0]  bus_rdata
);
    import pdg_pkg::*;

    logic dbg_brk;
    logic sel_mode, sel_mask, sel_fctl, sel_dtlo, sel_dthi;

    // address decode of write strobes
    assign sel_mode = bus_wr && (bus_addr == A_MODE);
    assign sel_mask = bus_wr && (bus_addr == A_MASK);
    assign sel_fctl = bus_wr && (bus_addr == A_FCTL);
    assign sel_dtlo = bus_wr && (bus_addr == A_DTLO);
    assign sel_dthi = bus_wr && (bus_addr == A_DTHI);
    assign flag_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    // channel enables: a clearing fault overrides a write
    always_ff @(posedge clk) begin
        if (!rst_n)        chan_en <= '0;
        else if (kill_en)  chan_en <= '0;
        else if (sel_mode) chan_en <= bus_wdata[NCH-1:0];
    end

    // broadcast and pattern mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            com_mode <= 1'b0;
            pat_mode <= 1'b0;
        end else if (sel_mode) begin
            com_mode <= bus_wdata[4];
            pat_mode <= bus_wdata[5];
        end
    end

    // fault event mask
    always_ff @(posedge clk) begin
        if (!rst_n)        evt_mask <= '0;
        else if (sel_mask) evt_mask <= bus_wdata[NEVT-1:0];
    end

    // fault control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_act <= FA_NONE;
            cbc_mode  <= 1'b0;
            dbg_brk   <= 1'b0;
        end else if (sel_fctl) begin
            fault_act <= fact_e'(bus_wdata[1:0]);
            cbc_mode  <= bus_wdata[2];
            dbg_brk   <= bus_wdata[4];
        end
    end

    // dead-time counts (low-side one doubles as the pattern source)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_lo <= '0;
            dt_hi <= '0;
        end else begin
            if (sel_dtlo) dt_lo <= bus_wdata[DTW-1:0];
            if (sel_dthi) dt_hi <= bus_wdata[DTW-1:0];
        end
    end

    // read mux, unused bits return zero
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_MODE: begin
                bus_rdata[NCH-1:0] = chan_en;
                bus_rdata[4]       = com_mode;
                bus_rdata[5]       = pat_mode;
            end
            A_MASK: bus_rdata[NEVT-1:0] = evt_mask;
            A_FCTL: begin
                bus_rdata[1:0] = fault_act;
                bus_rdata[2]   = cbc_mode;
                bus_rdata[4]   = dbg_brk;
            end
            A_STAT: bus_rdata[0] = fault_flag;
            A_DTLO: bus_rdata[DTW-1:0] = dt_lo;
            A_DTHI: bus_rdata[DTW-1:0] = dt_hi;
            default: bus_rdata = '0;
        endcase
    end

    // R11
    kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en |=> (chan_en == '0));
endmodule

// File: rtl/pwm_dt_guard.sv
// Module: top of the PWM dead-time and fault guard. Routes each timer
// waveform (or channel A in broadcast mode) through a dead-time generator,
// selects per channel between generator, raw waveform and the latched
// pattern, and applies the fault force-low override last.
// Assumes all inputs are synchronous to clk; period_tick is one cycle wide.
module pwm_dt_guard #(
    parameter int unsigned NCH  = 4,
    parameter int unsigned NEVT = 8,
    parameter int unsigned DTW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    wave_in,
    input  logic              period_tick,
    input  logic [NEVT-1:0]   evt_in,
    output logic [2*NCH-1:0]  pin_out
);
    import pdg_pkg::*;

    localparam int unsigned NPIN = 2 * NCH;

    logic [NCH-1:0]  chan_en;
    logic            com_mode, pat_mode, cbc_mode;
    logic [NEVT-1:0] evt_mask;
    fact_e           fault_act;
    logic [DTW-1:0]  dt_lo, dt_hi;
    logic            flag_clr, fault_flag, force_low, kill_en;
    logic [NCH-1:0]  gen_in, gen_hs, gen_ls;
    logic [NPIN-1:0] pat_q;

    pdg_regs #(.NCH(NCH), .NEVT(NEVT), .DTW(DTW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .fault_flag(fault_flag), .kill_en(kill_en),
        .chan_en(chan_en), .com_mode(com_mode), .pat_mode(pat_mode),
        .evt_mask(evt_mask), .fault_act(fault_act), .cbc_mode(cbc_mode),
        .dt_lo(dt_lo), .dt_hi(dt_hi), .flag_clr(flag_clr),
        .bus_rdata(bus_rdata)
    );

    pdg_fault #(.NEVT(NEVT)) u_fault (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_mask(evt_mask),
        .fault_act(fault_act), .cbc_mode(cbc_mode), .period_tick(period_tick),
        .flag_clr(flag_clr), .fault_flag(fault_flag), .force_low(force_low),
        .kill_en(kill_en)
    );

    // one generator per channel, input picked by broadcast mode
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign gen_in[k] = com_mode ? wave_in[0] : wave_in[k];
        pdg_dtgen #(.DTW(DTW)) u_gen (
            .clk(clk), .rst_n(rst_n), .w_in(gen_in[k]),
            .dt_rise(dt_hi), .dt_fall(dt_lo),
            .hs_out(gen_hs[k]), .ls_out(gen_ls[k])
        );
    end

    // active pattern follows the low-side register only on update events
    always_ff @(posedge clk) begin
        if (!rst_n)           pat_q <= '0;
        else if (period_tick) pat_q <= dt_lo[NPIN-1:0];
    end

    // per-channel pin selection, then the fault override
    always_comb begin
        pin_out = '0;
        for (int k = 0; k < NCH; k++) begin
            if (pat_mode) begin
                pin_out[2*k]   = pat_q[2*k]   & chan_en[k];
                pin_out[2*k+1] = pat_q[2*k+1] & chan_en[k];
            end else if (chan_en[k]) begin
                pin_out[2*k]   = gen_ls[k];
                pin_out[2*k+1] = gen_hs[k];
            end else begin
                pin_out[2*k]   = 1'b0;
                pin_out[2*k+1] = wave_in[k];
            end
        end
        if (force_low) pin_out = '0;
    end

    // R7
    pat_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_mode |-> ((pin_out & ~pat_q) == '0));
endmodule

// File: tb/pwm_dt_guard_test.sv
module pwm_dt_guard_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [3:0] wave = 4'd0;
    logic       tick = 1'b0;
    logic [7:0] evt = 8'd0;
    logic [7:0] pins;

    pwm_dt_guard uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wave_in(wave),
        .period_tick(tick), .evt_in(evt), .pin_out(pins)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    logic [3:0] m_en, m_last, m_hs, m_ls;
    logic       m_com, m_pat, m_mode, m_dbg, m_flag, m_hold;
    logic [1:0] m_act;
    logic [7:0] m_mask, m_dtl, m_dth, m_patact;
    int         m_cnt [4];

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;

    task automatic model_step();
        logic fn;
        logic w;
        logic [1:0] old_act;
        if (!rst_n) begin
            m_en = 0; m_last = 0; m_hs = 0; m_ls = 0; m_com = 0; m_pat = 0;
            m_mode = 0; m_dbg = 0; m_flag = 0; m_hold = 0; m_act = 0;
            m_mask = 0; m_dtl = 0; m_dth = 0; m_patact = 0;
            for (int k = 0; k < 4; k++) m_cnt[k] = 0;
            return;
        end
        fn = |(evt & m_mask);
        old_act = m_act;
        for (int k = 0; k < 4; k++) begin
            w = m_com ? wave[0] : wave[k];
            if (w != m_last[k]) begin
                m_cnt[k] = w ? int'(m_dth) : int'(m_dtl);
                m_hs[k] = 0; m_ls[k] = 0;
            end else if (m_cnt[k] > 0) begin
                m_cnt[k] = m_cnt[k] - 1;
                m_hs[k] = 0; m_ls[k] = 0;
            end else begin
                m_hs[k] = w; m_ls[k] = !w;
            end
            m_last[k] = w;
        end
        if (tick) m_patact = m_dtl;
        if (fn) m_hold = 1; else if (tick) m_hold = 0;
        if (fn) m_flag = 1;
        else if (bus_wr && bus_addr == 3'd3 && bus_wdata[0]) m_flag = 0;
        if (bus_wr) begin
            case (bus_addr)
                3'd0: begin m_en = bus_wdata[3:0]; m_com = bus_wdata[4]; m_pat = bus_wdata[5]; end
                3'd1: m_mask = bus_wdata;
                3'd2: begin m_act = bus_wdata[1:0]; m_mode = bus_wdata[2]; m_dbg = bus_wdata[4]; end
                3'd4: m_dtl = bus_wdata;
                3'd5: m_dth = bus_wdata;
                default: ;
            endcase
        end
        if (fn && old_act == 2'b11) m_en = 0;
    endtask

    always @(posedge clk) model_step();

    function automatic logic [7:0] exp_pins();
        logic [7:0] p = 0;
        for (int k = 0; k < 4; k++) begin
            if (m_pat) begin
                p[2*k]   = m_patact[2*k]   & m_en[k];
                p[2*k+1] = m_patact[2*k+1] & m_en[k];
            end else if (m_en[k]) begin
                p[2*k] = m_ls[k]; p[2*k+1] = m_hs[k];
            end else begin
                p[2*k] = 0; p[2*k+1] = wave[k];
            end
        end
        if (m_act == 2'b01 && (m_mode ? m_hold : m_flag)) p = 0;
        return p;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {2'b00, m_pat, m_com, m_en};
            3'd1: return m_mask;
            3'd2: return {3'b000, m_dbg, 1'b0, m_mode, m_act};
            3'd3: return {7'd0, m_flag};
            3'd4: return m_dtl;
            3'd5: return m_dth;
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got,
                         input logic [7:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // one clock: sample at the falling edge, compare with the model
    task automatic cyc();
        @(negedge clk);
        check(tag, pins, exp_pins(), "pins");
        check(tag, bus_rdata, exp_rdata(bus_addr), "rdata");
    endtask

    task automatic write(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        cyc();
        check(req, bus_rdata, exp, "readback");
    endtask

    task automatic run(input int n, input int tper);
        for (int i = 0; i < n; i++) begin
            wave = wave ^ (4'($urandom) & 4'($urandom));
            tick = (i % tper) == (tper - 1);
            cyc();
            tick = 1'b0;
        end
    endtask

    task automatic gap(input int ch, input logic lvl, input int exp, input string req);
        int n = 0;
        wave[ch] = lvl;
        for (int i = 0; i < 300; i++) begin
            cyc();
            if (pins[2*ch +: 2] == 2'b00) n++;
            else break;
        end
        check(req, 8'(n), 8'(exp), "gap cycles");
        check(req, {6'd0, pins[2*ch +: 2]}, lvl ? 8'h02 : 8'h01, "pair after gap");
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        evt = e; cyc(); evt = 8'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        // R1: reset state
        tag = "R1";
        repeat (2) cyc();
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) read_chk(3'(a), 8'h00, "R1");
        check("R1", pins, 8'h00, "pins after reset");

        // R2: map and reserved bits
        tag = "R2";
        write(3'd0, 8'hFF); read_chk(3'd0, 8'h3F, "R2");
        write(3'd2, 8'hFF); read_chk(3'd2, 8'h17, "R2");
        write(3'd1, 8'hA5); read_chk(3'd1, 8'hA5, "R2");
        write(3'd4, 8'h3C); read_chk(3'd4, 8'h3C, "R2");
        write(3'd5, 8'hC3); read_chk(3'd5, 8'hC3, "R2");
        read_chk(3'd7, 8'h00, "R2");
        write(3'd2, 8'h00); write(3'd1, 8'h00); write(3'd0, 8'h00);

        // R3: disabled channels pass the raw waveform
        tag = "R3";
        run(40, 16);
        wave = 4'b1010; cyc();
        check("R3", pins, 8'h88, "raw passthrough");

        // R4: gap widths on both edges
        tag = "R4";
        wave = 4'd0;
        write(3'd4, 8'd3); write(3'd5, 8'd5); write(3'd0, 8'h0F);
        repeat (10) cyc();
        gap(0, 1'b1, 6, "R4");
        gap(0, 1'b0, 4, "R4");
        write(3'd4, 8'd0); write(3'd5, 8'd0);
        repeat (4) cyc();
        gap(2, 1'b1, 1, "R4");
        gap(2, 1'b0, 1, "R4");
        write(3'd4, 8'd2); write(3'd5, 8'd4);

        // R5: random edges, including edges inside gaps
        tag = "R5";
        run(300, 16);

        // R3 again with a mixed enable set
        tag = "R3";
        write(3'd0, 8'h05);
        run(100, 16);

        // R6: broadcast from channel A
        tag = "R6";
        write(3'd0, 8'h1F);
        run(150, 16);
        wave = 4'b0001; repeat (12) cyc();
        check("R6", pins, 8'hAA, "broadcast high");
        wave = 4'b1110; repeat (12) cyc();
        check("R6", pins, 8'h55, "broadcast low, B-D ignored");

        // R7: pattern mode with deferred load
        tag = "R7";
        write(3'd0, 8'h2B);
        write(3'd4, 8'h96);
        tick = 1'b1; cyc(); tick = 1'b0;
        check("R7", pins, 8'h86, "pattern after tick");
        write(3'd4, 8'hFF);
        repeat (3) cyc();
        check("R7", pins, 8'h86, "pattern held before tick");
        tick = 1'b1; cyc(); tick = 1'b0;
        check("R7", pins, 8'hCF, "new pattern after tick");
        write(3'd4, 8'd2);

        // R8: masked OR and sticky flag
        tag = "R8";
        write(3'd0, 8'h0F); write(3'd2, 8'h00); write(3'd1, 8'h10);
        pulse_evt(8'h08);
        read_chk(3'd3, 8'h00, "R8");
        pulse_evt(8'h10);
        read_chk(3'd3, 8'h01, "R8");
        write(3'd3, 8'h01);
        read_chk(3'd3, 8'h00, "R8");
        evt = 8'h18; write(3'd3, 8'h01); evt = 8'h00;
        read_chk(3'd3, 8'h01, "R8");
        write(3'd3, 8'h01);

        // R9: latched force low
        tag = "R9";
        write(3'd2, 8'h01);
        pulse_evt(8'h10);
        run(10, 16);
        check("R9", pins, 8'h00, "forced low");
        run(10, 16);
        check("R9", pins, 8'h00, "still forced across ticks");
        wave = 4'hF; write(3'd3, 8'h01);
        repeat (10) cyc();
        check("R9", pins, 8'hAA, "released after clear");

        // R10: cycle-by-cycle force low
        tag = "R10";
        write(3'd2, 8'h05);
        evt = 8'h10; repeat (3) cyc();
        tick = 1'b1; cyc(); tick = 1'b0;
        check("R10", pins, 8'h00, "held while fault present at tick");
        evt = 8'h00; repeat (3) cyc();
        check("R10", pins, 8'h00, "held until tick");
        tick = 1'b1; cyc(); tick = 1'b0;
        check("R10", pins, 8'hAA, "released at fault-free tick");
        read_chk(3'd3, 8'h01, "R10");
        write(3'd3, 8'h01);

        // R11: clear-enables action and no-op actions
        tag = "R11";
        write(3'd2, 8'h03);
        pulse_evt(8'h10);
        read_chk(3'd0, 8'h00, "R11");
        wave = 4'b0101; cyc();
        check("R11", pins, 8'h22, "raw after enables cleared");
        write(3'd3, 8'h01); write(3'd0, 8'h0F); write(3'd2, 8'h02);
        repeat (10) cyc();
        pulse_evt(8'h10);
        repeat (3) cyc();
        read_chk(3'd0, 8'h0F, "R11");
        check("R11", pins, 8'h66, "reserved action no effect");
        write(3'd3, 8'h01); write(3'd2, 8'h00);
        pulse_evt(8'h10);
        cyc();
        check("R11", pins, 8'h66, "action none no effect");
        write(3'd3, 8'h01);

        // R12: debug bit stored only
        tag = "R12";
        write(3'd2, 8'h10);
        read_chk(3'd2, 8'h10, "R12");
        repeat (4) cyc();
        check("R12", pins, 8'h66, "debug bit no effect");
        run(60, 16);

        finish_run();
    end
endmodule